// File: doc/BRIEF.md
# Synchronous Serial Port with Sticky Status Flags

This block is a byte-wide SPI port that runs either as the clock-driving master or as a clocked slave. A host side sees one control register and one data buffer. Writing the buffer loads an internal shift register; a finished byte moves from the shift register into the buffer, where the host reads it. In master mode a host write also starts the transfer, with SCK derived from the system clock by one of three fixed dividers. In slave mode the port follows an external SCK, optionally gated by an active-low select, through a small input synchronizer.

Two sticky flags sit in the top bits of the control register. The collision flag records a buffer write that arrived while a byte was still moving. The overflow flag records a slave byte that finished while the buffer still held an unread byte; that new byte is thrown away. The flags stay up until the host writes the control register with a 0 in that bit position. Because a master transfer is always host-initiated, the overflow flag can never rise in master mode, and the host must read the buffer after every slave byte, even when it only wants to send.

Top module: `spi_port`

## Requirements
- R1: The control register reads as {collision flag bit 7, overflow flag bit 6, enable bit 5, clock polarity bit 4, mode field bits 3:0} and is all zero after reset.
- R2: With enable at 1, mode 0000, 0001 and 0010 select master with a half SCK period of 2, 8 and 32 clocks, so the received byte lands in the buffer 32, 128 and 512 clocks after the accepting buffer-write edge; with enable at 0 or any mode other than those and 0100/0101, sck_oe_o and sdo_oe_o stay 0 and buffer writes are ignored.
- R3: In master mode the overflow flag never sets; a finished master byte always replaces the buffer contents, even if the buffer was never read.
- R4: A buffer write while a byte is in progress (master running, or slave past its first leading edge) sets the collision flag and is discarded; the transfer in progress keeps its data.
- R5: In slave mode a byte that finishes while the buffer is full sets the overflow flag, and the buffer and buffer-full status keep the old byte.
- R6: A control write with 0 in bit 7 or bit 6 clears that flag; a 1 there leaves the flag unchanged; nothing else clears the flags.
- R7: buf_full_o rises when a received byte enters the buffer and falls on the clock after a buffer read; buf_rdata_o shows the buffer.
- R8: In master mode SCK idles at the polarity bit (1 = high, 0 = low) and makes exactly 16 transitions per byte.
- R9: Data moves MSB first; outgoing bits change on the SCK edge leaving idle and incoming bits are sampled on the edge returning to idle.
- R10: In mode 0100 the slave ignores SCK and releases SDO while ss_ni is high; raising ss_ni mid-byte restarts the bit count so that the next byte starts clean and a buffer write is accepted again.
- R11: In mode 0101 the slave transfers bytes and drives SDO regardless of ss_ni.
- R12: Slave inputs pass a two-stage synchronizer; a slave byte lands in the buffer on the third clock edge after the final returning SCK edge at the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control register write data |
| ctrl_o | output | 8 | Control register contents including flags |
| buf_we_i | input | 1 | Buffer write strobe (loads outgoing byte) |
| buf_wdata_i | input | DATA_W | Buffer write data |
| buf_re_i | input | 1 | Buffer read strobe |
| buf_rdata_o | output | DATA_W | Received byte held in the buffer |
| buf_full_o | output | 1 | Buffer holds an unread byte |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe_o | output | 1 | Serial clock output enable |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Serial data output enable |
| ss_ni | input | 1 | Slave select, active low |

## Verification
A wrong bit counter or divider shows up as a buffer-full rise on the wrong clock, which the per-clock comparison of buffer and control outputs catches on the very cycle it happens. A flag that sets or clears on the wrong event appears in ctrl_o on the next clock and is flagged there, and a lost or overwritten byte appears on buf_rdata_o at once. Serial ordering errors surface as a wrong loopback byte in master mode and a wrong bit pattern on SDO in slave mode, checked at the end of each byte.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef struct packed {
    logic       wcol;
    logic       ovf;
    logic       en;
    logic       cpol;
    logic [3:0] mode;
  } ctrl_t;

  typedef enum logic [1:0] {
    ROLE_OFF    = 2'd0,
    ROLE_MASTER = 2'd1,
    ROLE_SLAVE  = 2'd2
  } role_e;

  localparam logic [3:0] MODE_M_FAST  = 4'b0000;
  localparam logic [3:0] MODE_M_MID   = 4'b0001;
  localparam logic [3:0] MODE_M_SLOW  = 4'b0010;
  localparam logic [3:0] MODE_S_SEL   = 4'b0100;
  localparam logic [3:0] MODE_S_NOSEL = 4'b0101;

  function automatic role_e role_of(input logic en, input logic [3:0] mode);
    if (!en) return ROLE_OFF;
    case (mode)
      MODE_M_FAST, MODE_M_MID, MODE_M_SLOW: return ROLE_MASTER;
      MODE_S_SEL, MODE_S_NOSEL:             return ROLE_SLAVE;
      default:                              return ROLE_OFF;
    endcase
  endfunction

endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] q_prev_o
);
  logic [STAGES:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int k = 1; k <= STAGES; k++) chain_q[k] <= chain_q[k-1];
    end
  end

  assign q_o      = chain_q[STAGES-1];
  assign q_prev_o = chain_q[STAGES];
endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned HALF_FAST = 2,
  parameter int unsigned HALF_MID  = 8,
  parameter int unsigned HALF_SLOW = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       start_i,
  input  logic [1:0] rate_i,
  output logic       busy_o,
  output logic       sck_act_o,
  output logic       lead_o,
  output logic       trail_o
);
  localparam int unsigned HC_W = (HALF_SLOW > 1) ? $clog2(HALF_SLOW) : 1;
  localparam int unsigned PH_N = 2 * DATA_W;
  localparam int unsigned PH_W = $clog2(PH_N);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_N - 1);

  logic [HC_W-1:0] hc_q, half_m1;
  logic [PH_W-1:0] ph_q;
  logic            busy_q, sck_q, tick;

  always_comb begin
    case (rate_i)
      2'd0:    half_m1 = HC_W'(HALF_FAST - 1);
      2'd1:    half_m1 = HC_W'(HALF_MID - 1);
      default: half_m1 = HC_W'(HALF_SLOW - 1);
    endcase
  end

  assign tick = busy_q && (hc_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      hc_q   <= '0;
      ph_q   <= '0;
    end else if (!run_i) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      hc_q   <= '0;
      ph_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        hc_q   <= '0;
        ph_q   <= '0;
      end
    end else if (tick) begin
      hc_q  <= '0;
      sck_q <= ~sck_q;
      ph_q  <= ph_q + 1'b1;
      if (ph_q == PH_LAST) busy_q <= 1'b0;
    end else begin
      hc_q <= hc_q + 1'b1;
    end
  end

  assign busy_o    = busy_q;
  assign sck_act_o = sck_q;
  assign lead_o    = tick && !ph_q[0];
  assign trail_o   = tick && ph_q[0];

  // R2: the last returning edge ends the byte
  p_byte_ends_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick && ph_q == PH_LAST) |=> !busy_q);
  // R8: SCK back at idle whenever the master is idle
  p_sck_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !busy_q) |-> !sck_q);
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              lead_i,
  input  logic              trail_i,
  input  logic              sdi_i,
  input  logic              abort_i,
  output logic              sdo_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              in_byte_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sdo_q, inb_q;

  assign done_o = trail_i && !abort_i && (cnt_q == CNT_LAST);
  assign rx_o   = {sh_q[DATA_W-2:0], sdi_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sdo_q <= 1'b0;
      inb_q <= 1'b0;
    end else begin
      if (load_i) sh_q <= load_data_i;
      if (abort_i) begin
        cnt_q <= '0;
        inb_q <= 1'b0;
      end else begin
        if (lead_i) begin
          sdo_q <= sh_q[DATA_W-1];
          inb_q <= 1'b1;
        end
        if (trail_i) begin
          sh_q  <= rx_o;
          cnt_q <= done_o ? '0 : cnt_q + 1'b1;
          if (done_o) inb_q <= 1'b0;
        end
      end
    end
  end

  assign sdo_o     = sdo_q;
  assign in_byte_o = inb_q;

  // R10: losing select drops the partial byte
  p_abort_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (!inb_q && cnt_q == '0));
  // R9: a byte never finishes without having started on a leading edge
  p_done_needs_lead_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> inb_q);
endmodule

// File: rtl/spi_port_regs.sv
module spi_port_regs
  import spi_port_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  input  logic              buf_we_i,
  input  logic              buf_re_i,
  input  logic              active_i,
  input  logic              busy_i,
  input  logic              is_master_i,
  input  logic              is_slave_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] buf_o,
  output logic              full_o,
  output logic              accept_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] buf_q;
  logic              full_q, wcol_set, ovf_set;

  assign accept_o = buf_we_i && active_i && !busy_i;
  assign wcol_set = buf_we_i && active_i && busy_i;
  assign ovf_set  = done_i && is_slave_i && full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      buf_q  <= '0;
      full_q <= 1'b0;
    end else begin
      if (ctrl_we_i) begin
        ctrl_q.wcol <= ctrl_q.wcol & ctrl_wdata_i[7];
        ctrl_q.ovf  <= ctrl_q.ovf & ctrl_wdata_i[6];
        ctrl_q.en   <= ctrl_wdata_i[5];
        ctrl_q.cpol <= ctrl_wdata_i[4];
        ctrl_q.mode <= ctrl_wdata_i[3:0];
      end
      if (wcol_set) ctrl_q.wcol <= 1'b1;
      if (ovf_set)  ctrl_q.ovf  <= 1'b1;
      if (done_i && !ovf_set) begin
        buf_q  <= rx_i;
        full_q <= 1'b1;
      end else if (buf_re_i) begin
        full_q <= 1'b0;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign buf_o  = buf_q;
  assign full_o = full_q;

  // R3: no overflow while acting as master
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_master_i && !ctrl_q.ovf) |=> !ctrl_q.ovf);
  // R4: collision flag is sticky without a control write
  p_wcol_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.wcol && !ctrl_we_i) |=> ctrl_q.wcol);
  // R5: an overflowing byte leaves the buffer alone
  p_ovf_keeps_buf_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_set |=> ($stable(buf_q) && full_q && ctrl_q.ovf));
  // R7: a read without a new byte empties the buffer
  p_read_empties_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf_re_i && !done_i) |=> !full_q);
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HALF_FAST   = 2,
  parameter int unsigned HALF_MID    = 8,
  parameter int unsigned HALF_SLOW   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [7:0]        ctrl_wdata_i,
  output logic [7:0]        ctrl_o,
  input  logic              buf_we_i,
  input  logic [DATA_W-1:0] buf_wdata_i,
  input  logic              buf_re_i,
  output logic [DATA_W-1:0] buf_rdata_o,
  output logic              buf_full_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  input  logic              ss_ni
);
  ctrl_t ctrl;
  role_e role;
  logic  is_master, is_slave, active, ss_ign, selected;
  logic  [2:0] syn, syn_prev;
  logic  sck_s, sck_p, sdi_s, ss_s, s_chg, s_lead, s_trail;
  logic  m_busy, m_sck, m_lead, m_trail;
  logic  lead, trail, abort, sh_sdi, done, in_byte, busy, accept;
  logic  [DATA_W-1:0] rx;

  assign role      = role_of(ctrl.en, ctrl.mode);
  assign is_master = (role == ROLE_MASTER);
  assign is_slave  = (role == ROLE_SLAVE);
  assign active    = is_master || is_slave;
  assign ss_ign    = (ctrl.mode == MODE_S_NOSEL);

  spi_port_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .d_i      ({sck_i, sdi_i, ss_ni}),
    .q_o      (syn),
    .q_prev_o (syn_prev)
  );

  assign sck_s    = syn[2];
  assign sck_p    = syn_prev[2];
  assign sdi_s    = syn[1];
  assign ss_s     = syn[0];
  assign selected = is_slave && (ss_ign || !ss_s);
  assign s_chg    = selected && (sck_s != sck_p);
  assign s_lead   = s_chg && (sck_s != ctrl.cpol);
  assign s_trail  = s_chg && (sck_s == ctrl.cpol);

  spi_port_clkgen #(
    .DATA_W(DATA_W), .HALF_FAST(HALF_FAST), .HALF_MID(HALF_MID), .HALF_SLOW(HALF_SLOW)
  ) u_clkgen (
    .clk_i, .rst_ni,
    .run_i     (is_master),
    .start_i   (accept && is_master),
    .rate_i    (ctrl.mode[1:0]),
    .busy_o    (m_busy),
    .sck_act_o (m_sck),
    .lead_o    (m_lead),
    .trail_o   (m_trail)
  );

  assign lead   = is_master ? m_lead  : s_lead;
  assign trail  = is_master ? m_trail : s_trail;
  assign sh_sdi = is_master ? sdi_i   : sdi_s;
  assign abort  = !(is_master || selected);

  spi_port_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk_i, .rst_ni,
    .load_i      (accept),
    .load_data_i (buf_wdata_i),
    .lead_i      (lead),
    .trail_i     (trail),
    .sdi_i       (sh_sdi),
    .abort_i     (abort),
    .sdo_o       (sdo_o),
    .done_o      (done),
    .rx_o        (rx),
    .in_byte_o   (in_byte)
  );

  assign busy = is_master ? m_busy : in_byte;

  spi_port_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .ctrl_we_i, .ctrl_wdata_i, .buf_we_i, .buf_re_i,
    .active_i    (active),
    .busy_i      (busy),
    .is_master_i (is_master),
    .is_slave_i  (is_slave),
    .done_i      (done),
    .rx_i        (rx),
    .ctrl_o      (ctrl),
    .buf_o       (buf_rdata_o),
    .full_o      (buf_full_o),
    .accept_o    (accept)
  );

  assign ctrl_o   = ctrl;
  assign sck_o    = ctrl.cpol ^ (is_master && m_sck);
  assign sck_oe_o = is_master;
  assign sdo_oe_o = is_master || selected;

  // R8: idle master SCK sits at the polarity level
  p_idle_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_master && !m_busy) |-> (sck_o == ctrl.cpol));
  // R2: inactive port never drives the pins
  p_released_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> (!sck_oe_o && !sdo_oe_o && !done));
  // R10: with select honoured and high, no bit is taken in
  p_ss_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_slave && !ss_ign && ss_s) |-> (!done && !sdo_oe_o));
endmodule

// File: tb/spi_port_test.sv
module spi_port_test;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_ni, ctrl_we, buf_we, buf_re, sck_drv, sdi_drv, ss_n, loop;
  logic [7:0] ctrl_wdata, buf_wdata, ctrl_o, buf_rdata;
  logic       buf_full, sck_o, sck_oe, sdo_o, sdo_oe, sdi_w;

  always #4 clk = ~clk;
  assign sdi_w = loop ? sdo_o : sdi_drv;

  spi_port uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_o(ctrl_o),
    .buf_we_i(buf_we), .buf_wdata_i(buf_wdata), .buf_re_i(buf_re),
    .buf_rdata_o(buf_rdata), .buf_full_o(buf_full),
    .sck_i(sck_drv), .sck_o(sck_o), .sck_oe_o(sck_oe),
    .sdi_i(sdi_w), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe), .ss_ni(ss_n)
  );

  int   n_chk = 0, n_bad = 0, sck_edges = 0;
  logic [7:0] exp_ctrl = 8'h00, exp_buf = 8'h00;
  logic exp_full = 1'b0, cmp_en = 1'b0, sck_prev = 1'b0, finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  // reference state compared every clock
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(ctrl_o == exp_ctrl, "R1 ctrl_o", ctrl_o, exp_ctrl);
      chk(buf_full == exp_full, "R7 buf_full_o", buf_full, exp_full);
      chk(buf_rdata == exp_buf, "R7 buf_rdata_o", buf_rdata, exp_buf);
    end
    if (sck_o !== sck_prev) sck_edges++;
    sck_prev = sck_o;
  end

  task automatic host_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(posedge clk);
    exp_ctrl = {exp_ctrl[7] & v[7], exp_ctrl[6] & v[6], v[5:0]};
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic host_write(input logic [7:0] v, input bit collide);
    @(negedge clk); buf_we = 1'b1; buf_wdata = v;
    @(posedge clk);
    if (collide) exp_ctrl[7] = 1'b1;
    @(negedge clk); buf_we = 1'b0;
  endtask

  task automatic host_read();
    @(negedge clk); buf_re = 1'b1;
    @(posedge clk);
    exp_full = 1'b0;
    @(negedge clk); buf_re = 1'b0;
  endtask

  task automatic master_xfer(input logic [7:0] v, input int half, input bit collide);
    @(negedge clk); sck_edges = 0;
    host_write(v, 1'b0);
    if (collide) begin
      repeat (8 * half) @(posedge clk);
      host_write(8'h3C, 1'b1);
      repeat (8 * half - 1) @(posedge clk);
    end else begin
      repeat (16 * half) @(posedge clk);
    end
    exp_buf = v; exp_full = 1'b1;
    repeat (2) @(negedge clk);
    chk(sck_edges == 16, "R8 sck transitions", sck_edges, 16);
    chk(sck_o == exp_ctrl[4], "R8 sck idle after byte", sck_o, exp_ctrl[4]);
  endtask

  // bench acts as the remote master; cpol taken from the programmed control value
  task automatic slave_byte(input logic [7:0] mosi, input bit chk_tx, input logic [7:0] tx_exp,
                            input bit collide, input bit expect_rx);
    logic c;
    logic [7:0] got;
    c = exp_ctrl[4];
    got = 8'h00;
    for (int b = 7; b >= 0; b--) begin
      @(negedge clk); sck_drv = ~c; sdi_drv = mosi[b];
      if (collide && b == 4) host_write(8'h99, 1'b1);
      repeat (H) @(negedge clk);
      got[b] = sdo_o;
      sck_drv = c;
      if (b == 0) begin
        repeat (3) @(posedge clk);
        if (expect_rx) begin
          if (exp_full) exp_ctrl[6] = 1'b1;
          else begin exp_buf = mosi; exp_full = 1'b1; end
        end
        repeat (H) @(negedge clk);
      end else begin
        repeat (H - 1) @(negedge clk);
      end
    end
    if (chk_tx) chk(got == tx_exp, "R9 slave sdo msb first", got, tx_exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; ctrl_we = 1'b0; buf_we = 1'b0; buf_re = 1'b0;
    ctrl_wdata = 8'h00; buf_wdata = 8'h00;
    sck_drv = 1'b0; sdi_drv = 1'b0; ss_n = 1'b1; loop = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1; cmp_en = 1'b1;
    @(negedge clk);
    chk(ctrl_o == 8'h00, "R1 reset value", ctrl_o, 0);
    chk(!sck_oe && !sdo_oe, "R2 pins released at reset", {sck_oe, sdo_oe}, 0);

    // disabled and reserved modes
    host_write(8'h81, 1'b0);
    repeat (40) @(negedge clk);
    chk(!sck_oe && !sdo_oe, "R2 disabled pins", {sck_oe, sdo_oe}, 0);
    host_ctrl(8'h23);
    host_write(8'h81, 1'b0);
    repeat (40) @(negedge clk);
    chk(!sck_oe && !sdo_oe, "R2 reserved mode pins", {sck_oe, sdo_oe}, 0);

    // master fast, cpol 0, loopback
    loop = 1'b1;
    host_ctrl(8'h20);
    @(negedge clk);
    chk(sck_o == 1'b0 && sck_oe, "R8 idle low", sck_o, 0);
    master_xfer(8'hA5, 2, 1'b0);
    chk(buf_rdata == 8'hA5, "R9 master loopback", buf_rdata, 8'hA5);
    host_read();

    // master mid, cpol 1, with collision
    host_ctrl(8'h31);
    @(negedge clk);
    chk(sck_o == 1'b1, "R8 idle high", sck_o, 1);
    master_xfer(8'hC3, 8, 1'b1);
    chk(buf_rdata == 8'hC3, "R4 collision write discarded", buf_rdata, 8'hC3);
    repeat (20) @(negedge clk);
    chk(ctrl_o[7] == 1'b1, "R4 collision sticky", ctrl_o[7], 1);

    // master slow, buffer not read: overwrite, no overflow
    host_ctrl(8'hB2);
    chk(ctrl_o[7] == 1'b1, "R6 write 1 keeps flag", ctrl_o[7], 1);
    master_xfer(8'h6E, 32, 1'b0);
    chk(ctrl_o[6] == 1'b0, "R3 no overflow in master", ctrl_o[6], 0);
    chk(buf_rdata == 8'h6E, "R3 master overwrites buffer", buf_rdata, 8'h6E);
    host_ctrl(8'h32);
    chk(ctrl_o[7] == 1'b0, "R6 write 0 clears flag", ctrl_o[7], 0);
    host_read();
    loop = 1'b0;

    // slave, select ignored
    host_ctrl(8'h25);
    repeat (5) @(negedge clk);
    chk(sdo_oe == 1'b1, "R11 sdo driven with ss high", sdo_oe, 1);
    host_write(8'hC6, 1'b0);
    slave_byte(8'h5A, 1'b1, 8'hC6, 1'b0, 1'b1);
    chk(buf_rdata == 8'h5A && buf_full, "R11 byte received with ss high", buf_rdata, 8'h5A);
    slave_byte(8'h0F, 1'b0, 8'h00, 1'b0, 1'b1);
    chk(ctrl_o[6] == 1'b1, "R5 overflow set", ctrl_o[6], 1);
    chk(buf_rdata == 8'h5A, "R5 old byte kept", buf_rdata, 8'h5A);
    host_ctrl(8'h65);
    chk(ctrl_o[6] == 1'b1, "R6 write 1 keeps overflow", ctrl_o[6], 1);
    host_read();
    host_ctrl(8'h25);
    chk(ctrl_o[6] == 1'b0, "R6 overflow cleared", ctrl_o[6], 0);
    slave_byte(8'h81, 1'b0, 8'h00, 1'b1, 1'b1);
    chk(ctrl_o[7] == 1'b1, "R4 slave collision", ctrl_o[7], 1);
    chk(buf_rdata == 8'h81, "R12 slave byte latency", buf_rdata, 8'h81);
    host_read();
    host_ctrl(8'h25);

    // slave, select honoured
    host_ctrl(8'h24);
    repeat (5) @(negedge clk);
    chk(sdo_oe == 1'b0, "R10 sdo released ss high", sdo_oe, 0);
    slave_byte(8'hFF, 1'b0, 8'h00, 1'b0, 1'b0);
    chk(buf_full == 1'b0, "R10 edges ignored ss high", buf_full, 0);
    @(negedge clk); ss_n = 1'b0;
    repeat (5) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); sck_drv = 1'b1; sdi_drv = 1'b1;
      repeat (H) @(negedge clk);
      sck_drv = 1'b0;
      repeat (H - 1) @(negedge clk);
    end
    @(negedge clk); ss_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(sdo_oe == 1'b0, "R10 sdo released mid byte", sdo_oe, 0);
    ss_n = 1'b0;
    repeat (5) @(negedge clk);
    host_write(8'h4B, 1'b0);
    chk(ctrl_o[7] == 1'b0, "R10 write accepted after abort", ctrl_o[7], 0);
    slave_byte(8'h96, 1'b1, 8'h4B, 1'b0, 1'b1);
    chk(buf_rdata == 8'h96, "R10 clean byte after abort", buf_rdata, 8'h96);
    host_read();
    repeat (4) @(negedge clk);

    finished = 1'b1;
    cmp_en = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule